// File: doc/BRIEF.md
# Double-Buffered Parallel Output Port

This block takes an 8-bit word from a host over a parallel bus and drives eight switch-control outputs, one per bit. The host pulls an active-low select line, then an active-low write strobe. While both are low, a staging register tracks the bus. When the strobe rises, the staging register freezes. When the select line rises, the staged word moves into the output register in a single step, so the eight outputs never pass through partly written values.

A second way of use needs no host timing at all. If both control lines are held low when reset is released, the block enters a direct mode and stays there until the next reset. In direct mode the outputs follow the data bus every clock. The control lines and the bus are asynchronous to the block clock, so each passes through a synchronizer before any edge detection or sampling. A mode output tells which of the two behaviours is in force.

Top module: `par_out_port`

## Requirements
- R1: While reset is asserted, and right after it, the output word is all zeros. The staging register is also cleared, so a select pulse without a write after reset leaves the output at zero.
- R2: Strobe pulses and bus changes while the select line is high do not touch the staging register. A later select pulse with no write leaves the output word unchanged.
- R3: While select and strobe are both low, the staging register follows the bus. The last value present before the strobe rises is the one that is transferred.
- R4: Bus changes after the strobe rises do not reach the staging register or the output.
- R5: In host mode the output word changes only on a rising edge of the select line. Before that edge it keeps its previous value.
- R6: Output bit i is driven by bus bit i.
- R7: If both control lines are low when reset is released, the mode output reads 1 and the output word follows the bus within a few clocks, with no strobes.
- R8: If either control line is high when reset is released, the mode output reads 0. Holding both lines low later does not switch the block into direct mode.
- R9: If select and strobe rise together, the word staged in that write is the one transferred to the outputs.
- R10: Direct mode lasts until the next reset whatever the control lines do, and a reset with a control line high returns the block to host mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| wr_n | input | 1 | Active-low write strobe from the host, asynchronous |
| din | input | WIDTH | Parallel data bus, asynchronous |
| dout | output | WIDTH | Output word, one bit per switch |
| direct_mode | output | 1 | 1 = direct mode, 0 = host mode |

## Verification
The bench moves the bus several times while a write is open. A design that sampled the bus only once would transfer an early value instead of the last one. It also changes the bus after the strobe rises, and it checks the outputs before the select line rises: a design with a single register, or one whose staging stage stays open, would let the outputs move early or take the late data. The bench raises the strobe and select in the same step, which exposes a design that skips the transfer or loses the final write. It also holds both lines low long after a host-mode reset and toggles the lines in direct mode, which catches a mode decision that is not locked at reset release.

// File: rtl/par_out_port.sv
module par_out_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             direct_mode
);

  localparam int CW = $clog2(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] cs_sh, wr_sh;
  logic [WIDTH-1:0]       d_sh [SYNC_STAGES];
  logic                   cs_s, wr_s, cs_q;
  logic [WIDTH-1:0]       d_s, latch;
  logic [CW-1:0]          settle;
  logic                   decided, direct;
  logic                   host_on, cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '1;
      wr_sh <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) d_sh[i] <= '0;
    end else begin
      cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      wr_sh   <= {wr_sh[SYNC_STAGES-2:0], wr_n};
      d_sh[0] <= din;
      for (int i = 1; i < SYNC_STAGES; i++) d_sh[i] <= d_sh[i-1];
    end
  end

  assign cs_s = cs_sh[SYNC_STAGES-1];
  assign wr_s = wr_sh[SYNC_STAGES-1];
  assign d_s  = d_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle  <= '0;
      decided <= 1'b0;
      direct  <= 1'b0;
    end else if (!decided) begin
      if (settle == CW'(SYNC_STAGES)) begin
        decided <= 1'b1;
        direct  <= !cs_s && !wr_s;
      end else begin
        settle <= settle + 1'b1;
      end
    end
  end

  assign host_on = decided && !direct;
  assign cs_rise = cs_s && !cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      latch <= '0;
      dout  <= '0;
    end else begin
      cs_q <= cs_s;
      if (host_on && !cs_s && !wr_s) latch <= d_s;
      if (direct)                    dout  <= d_s;
      else if (host_on && cs_rise)   dout  <= latch;
    end
  end

  assign direct_mode = direct;

endmodule

// File: rtl/par_out_port_chk.sv
module par_out_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             wr_s,
  input logic             cs_q,
  input logic             host_on,
  input logic [WIDTH-1:0] latch,
  input logic [WIDTH-1:0] d_s,
  input logic [WIDTH-1:0] dout,
  input logic             direct_mode
);

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (dout == '0); // R1
  end

  AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || wr_s) |=> $stable(latch)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && !(cs_s && !cs_q)) |=> $stable(dout)); // R5

  AST_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (host_on && cs_s && !cs_q) |=> (dout == $past(latch))); // R9

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |=> (dout == $past(d_s))); // R7

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |=> direct_mode); // R10

endmodule

bind par_out_port par_out_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .wr_s(wr_s), .cs_q(cs_q),
  .host_on(host_on), .latch(latch), .d_s(d_s), .dout(dout),
  .direct_mode(direct_mode)
);

// File: tb/test_par_out_port.sv
module test_par_out_port;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic direct_mode;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  par_out_port i_par_out_port (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .din(din), .dout(dout), .direct_mode(direct_mode));

  // {mid[16:9], final[8:1], same_edge[0]}
  localparam logic [16:0] VEC [6] = '{
    {8'h00, 8'hA5, 1'b0}, {8'hFF, 8'h01, 1'b0}, {8'h3C, 8'h80, 1'b1},
    {8'h55, 8'h5A, 1'b0}, {8'h0F, 8'hFF, 1'b1}, {8'hAA, 8'h00, 1'b0}};

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic c, input logic w);
    cs_n = c; wr_n = w; rst_n = 0;
    tick(3);
    chk(dout == '0, "R1 reset", dout, '0);
    rst_n = 1;
    tick(6);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    do_reset(1'b1, 1'b1);
    chk(direct_mode == 1'b0, "R8 host mode", {7'b0, direct_mode}, 8'h00);
    // R1: select pulse without write after reset
    cs_n = 0; tick(4); cs_n = 1; tick(5);
    chk(dout == '0, "R1 latch cleared", dout, '0);

    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] mid, fin;
      mid = VEC[k][16:9]; fin = VEC[k][8:1];
      prev = dout;
      cs_n = 0; tick(4);
      wr_n = 0; din = mid; tick(4);
      din = fin; tick(4);
      chk(dout == prev, "R5 hold during write", dout, prev);
      if (VEC[k][0]) begin
        cs_n = 1; wr_n = 1;   // R9 same edge
      end else begin
        wr_n = 1; tick(1);
        din = ~fin; tick(5);  // R4 late data
        chk(dout == prev, "R5 hold before select rise", dout, prev);
        cs_n = 1;
      end
      tick(5);
      chk(dout == fin, "R3 R4 R6 R9 transfer", dout, fin);
    end

    // R2: strobe with select high
    prev = dout;
    din = 8'hC3; wr_n = 0; tick(4); wr_n = 1; tick(4);
    cs_n = 0; tick(4); cs_n = 1; tick(5);
    chk(dout == prev, "R2 strobe ignored", dout, prev);

    // R8: both low long after reset does not switch mode
    prev = dout;
    din = 8'h99; cs_n = 0; wr_n = 0; tick(20);
    chk(direct_mode == 1'b0, "R8 no late switch", {7'b0, direct_mode}, 8'h00);
    chk(dout == prev, "R8 outputs held", dout, prev);
    wr_n = 1; cs_n = 1; tick(5);
    chk(dout == 8'h99, "R3 transfer after long write", dout, 8'h99);

    // R7: direct mode
    din = 8'h00;
    do_reset(1'b0, 1'b0);
    chk(direct_mode == 1'b1, "R7 direct selected", {7'b0, direct_mode}, 8'h01);
    for (int b = 0; b < W; b++) begin
      din = W'(1) << b; tick(4);
      chk(dout == (W'(1) << b), "R6 R7 direct follow", dout, W'(1) << b);
    end
    // R10: controls released, mode sticks
    cs_n = 1; wr_n = 1; din = 8'h6E; tick(4);
    chk(direct_mode == 1'b1, "R10 mode sticky", {7'b0, direct_mode}, 8'h01);
    chk(dout == 8'h6E, "R10 still follows", dout, 8'h6E);
    cs_n = 0; tick(4); cs_n = 1; din = 8'h17; tick(4);
    chk(dout == 8'h17, "R10 strobes no effect", dout, 8'h17);
    do_reset(1'b1, 1'b0);
    chk(direct_mode == 1'b0, "R10 reset to host", {7'b0, direct_mode}, 8'h00);
    chk(dout == '0, "R1 cleared after mode change", dout, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule